// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

A four-bit counter that steps up or down once per rising clock edge. A build-time parameter selects either plain binary counting over 0–15 or decade counting over 0–9. A synchronous, active-low load copies a four-bit value into the count. Two active-low enables must both be asserted for the count to move. The first enable is shared by every stage of a chain. The second enable also gates the active-low terminal-count flag.

Several counters form a wider one by feeding each stage's terminal-count output into the next stage's chain enable. All stages share the clock, the load, the direction and the shared enable. The terminal-count flag is combinational, so a carry ripples through the whole chain within the same cycle. In decade mode the six unused codes 10–15 lead back into the legal range after at most two counts. There is no reset. A known state is set through the load path.

Top module: `updown_counter4`

## Requirements
- R1: The count changes only on a rising clock edge. Changing the load, data or enable inputs between edges leaves `q` unchanged.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `din`, whatever the enables and direction are.
- R3: When `load_n` is 1 and either `par_en_n` or `chain_en_n` is 1, `q` holds its value across the edge.
- R4: Counting (`load_n`=1, both enables 0) with `dir_up`=1 adds one. The count wraps from 15 to 0 in binary mode and from 9 to 0 in decade mode.
- R5: Counting with `dir_up`=0 subtracts one. The count wraps from 0 to 15 in binary mode and from 0 to 9 in decade mode.
- R6: `term_n` is 0 only while `chain_en_n` is 0 and the count sits at its end for the current direction. In up mode the end is 15 for binary and 9 for decade. In down mode the end is 0.
- R7: `term_n` does not depend on `par_en_n`.
- R8: In decade up mode, `term_n` is 0 whenever bits 0 and 3 of `q` are both 1. This covers 9 and also the unused codes 11, 13 and 15.
- R9: In decade up counting, 10 goes to 11, 12 goes to 13 and 14 goes to 15. The codes 11, 13 and 15 go to 0.
- R10: In decade down counting, any code from 10 to 15 goes to 9.
- R11: Three decade stages chained through `term_n` → `chain_en_n` count 000 to 999 and wrap in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change occurs on its rising edge |
| load_n | input | 1 | Active-low synchronous load of `din` |
| din | input | 4 | Value loaded into the count |
| par_en_n | input | 1 | Active-low count enable shared by all stages of a chain |
| chain_en_n | input | 1 | Active-low count enable that also gates `term_n` |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| q | output | 4 | Current count |
| term_n | output | 1 | Active-low terminal count, combinational |

## Verification
Every change to `q` from a load, a count or a hold is due one edge after the inputs that cause it. The bench drives inputs on the falling edge and reads `q` on the next falling edge, half a period after the rising edge that updated it. `term_n` has no register in its path. It is read a nanosecond after its inputs change, before any rising edge, and read again after `par_en_n` is toggled to show it has no effect. In the chain, each stage's carry settles within the same cycle, so the combined three-digit value is compared at every falling edge.

// File: rtl/updown_counter4.sv
module updown_counter4 #(
  parameter bit DECADE = 1'b0
) (
  input  logic       clk,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       par_en_n,
  input  logic       chain_en_n,
  input  logic       dir_up,
  output logic [3:0] q,
  output logic       term_n
);

  localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

  logic [3:0] cnt, cnt_inc, cnt_dec;
  logic       run, at_top, at_bot;

  assign run     = load_n & ~par_en_n & ~chain_en_n;
  assign at_top  = DECADE ? (cnt[0] & cnt[3]) : (cnt == 4'd15);
  assign at_bot  = (cnt == 4'd0);
  assign cnt_inc = at_top ? 4'd0 : cnt + 4'd1;
  assign cnt_dec = (at_bot || cnt > TOP) ? TOP : cnt - 4'd1;

  always_ff @(posedge clk) begin
    if (!load_n)  cnt <= din;
    else if (run) cnt <= dir_up ? cnt_inc : cnt_dec;
  end

  assign q      = cnt;
  assign term_n = ~(~chain_en_n & (dir_up ? at_top : at_bot));

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!armed)
    !load_n |=> q == $past(din)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (load_n && (par_en_n || chain_en_n)) |=> $stable(q)); // R3
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !par_en_n && !chain_en_n && dir_up && q < TOP) |=> q == 4'($past(q) + 4'd1)); // R4
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !par_en_n && !chain_en_n && !dir_up && q != 4'd0 && q <= TOP) |=> q == 4'($past(q) - 4'd1)); // R5
  AST_TERM_GATED: assert property (@(posedge clk) disable iff (!armed)
    !term_n |-> !chain_en_n); // R6
  AST_DEC_UP_EXIT: assert property (@(posedge clk) disable iff (!armed)
    (DECADE && load_n && !par_en_n && !chain_en_n && dir_up && q > TOP && q[0]) |=> q == 4'd0); // R9
  AST_DEC_DN_EXIT: assert property (@(posedge clk) disable iff (!armed)
    (DECADE && load_n && !par_en_n && !chain_en_n && !dir_up && q > TOP) |=> q == TOP); // R10

endmodule

// File: tb/test_updown_counter4.sv
module test_updown_counter4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       load_n = 1'b1, pe_n = 1'b1, ce_n = 1'b1, up = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q_d, q_b;
  logic       tn_d, tn_b;

  updown_counter4 #(.DECADE(1'b1)) i_updown_counter4 (
    .clk(clk), .load_n(load_n), .din(din), .par_en_n(pe_n), .chain_en_n(ce_n),
    .dir_up(up), .q(q_d), .term_n(tn_d));
  updown_counter4 #(.DECADE(1'b0)) i_updown_counter4_bin (
    .clk(clk), .load_n(load_n), .din(din), .par_en_n(pe_n), .chain_en_n(ce_n),
    .dir_up(up), .q(q_b), .term_n(tn_b));

  logic       c_load_n = 1'b1, c_pe_n = 1'b1, c_up = 1'b1;
  logic [3:0] cq0, cq1, cq2;
  logic       ct0, ct1, ct2;
  updown_counter4 #(.DECADE(1'b1)) i_updown_counter4_s0 (
    .clk(clk), .load_n(c_load_n), .din(4'd0), .par_en_n(c_pe_n), .chain_en_n(1'b0),
    .dir_up(c_up), .q(cq0), .term_n(ct0));
  updown_counter4 #(.DECADE(1'b1)) i_updown_counter4_s1 (
    .clk(clk), .load_n(c_load_n), .din(4'd0), .par_en_n(c_pe_n), .chain_en_n(ct0),
    .dir_up(c_up), .q(cq1), .term_n(ct1));
  updown_counter4 #(.DECADE(1'b1)) i_updown_counter4_s2 (
    .clk(clk), .load_n(c_load_n), .din(4'd0), .par_en_n(c_pe_n), .chain_en_n(ct1),
    .dir_up(c_up), .q(cq2), .term_n(ct2));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(bit dec, int s, bit p, bit c, bit u);
    int top = dec ? 9 : 15;
    if (p || c) return s;
    if (u) begin
      if (dec) return (s % 2 == 1 && s >= 8) ? 0 : s + 1;
      return (s + 1) % 16;
    end
    if (s == 0 || s > top) return top;
    return s - 1;
  endfunction

  function automatic int term(bit dec, int s, bit c, bit u);
    if (c) return 1;
    if (u) return (dec ? (s % 2 == 1 && s >= 8) : (s == 15)) ? 0 : 1;
    return (s == 0) ? 0 : 1;
  endfunction

  function automatic string step_req(bit dec, int s, bit p, bit c, bit u);
    if (p || c) return "R3";
    if (dec && s > 9) return u ? "R9" : "R10";
    return u ? "R4" : "R5";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit p = c[0], e = c[1], u = c[2];
        @(negedge clk);
        load_n = 1'b0; din = 4'(s); pe_n = p; ce_n = e; up = u;
        @(negedge clk);
        chk("R2 decade load", q_d, s);
        chk("R2 binary load", q_b, s);
        load_n = 1'b1;
        #1;
        chk((s % 2 == 1 && s > 9 && u) ? "R8 decade term" : "R6 decade term", tn_d, term(1, s, e, u));
        chk("R6 binary term", tn_b, term(0, s, e, u));
        pe_n = ~p;
        #1;
        chk("R7 decade term", tn_d, term(1, s, e, u));
        chk("R7 binary term", tn_b, term(0, s, e, u));
        pe_n = p;
        @(negedge clk);
        chk(step_req(1, s, p, e, u), q_d, nxt(1, s, p, e, u));
        chk(step_req(0, s, p, e, u), q_b, nxt(0, s, p, e, u));
      end
    end

    @(negedge clk);
    load_n = 1'b0; din = 4'd3;
    @(negedge clk);
    din = 4'd12; pe_n = 1'b0; ce_n = 1'b0; up = 1'b1;
    #3;
    chk("R1 mid-cycle", q_d, 3);
    chk("R1 mid-cycle", q_b, 3);
    @(negedge clk);
    chk("R1 after edge", q_d, 12);
    chk("R1 after edge", q_b, 12);
    load_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 two counts decade", q_d, 0);
    chk("R4 binary", q_b, 14);

    @(negedge clk);
    c_load_n = 1'b0; c_pe_n = 1'b0; c_up = 1'b1;
    @(negedge clk);
    chk("R11 chain load", cq2 * 100 + cq1 * 10 + cq0, 0);
    c_load_n = 1'b1;
    for (int i = 1; i <= 1000; i++) begin
      @(negedge clk);
      chk("R11 chain up", cq2 * 100 + cq1 * 10 + cq0, i % 1000);
    end
    c_up = 1'b0;
    for (int i = 1; i <= 1000; i++) begin
      @(negedge clk);
      chk("R11 chain down", cq2 * 100 + cq1 * 10 + cq0, (1000 - i) % 1000);
    end
    c_pe_n = 1'b1;
    @(negedge clk);
    chk("R11 chain hold", cq2 * 100 + cq1 * 10 + cq0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule